// File: doc/BRIEF.md
# Packet Buffer Byte Access Port

This block lets a host reach any byte of a paged packet memory through a small register window. A 16-bit pointer register holds an 11-bit byte offset plus two control flags. One flag picks which page is reached: either the page at the head of the receive queue or the page named by the packet-number register. The other flag makes each data access advance the offset by one, wrapping within the 2048-byte page. Four data register offsets give the host a window into the page. When auto-increment is off, the low two bits of the data register offset are added to the pointer offset, so one pointer setting covers four neighbouring bytes.

The host reaches the port one byte per cycle through a read strobe, a write strobe, a 4-bit register offset and a byte of write data. The packet-number value and the receive-queue head come from neighbouring logic. The memory itself sits outside the block, behind a synchronous port. Register reads and memory reads both return their byte one cycle after the request, together with a valid strobe. A wider host access is split into consecutive single-byte accesses in ascending order, and each of them applies its own increment.

Top module: `buf_data_port`

## Requirements
- R1: After reset the pointer reads as 0x0000 and `rdata_valid` is low.
- R2: A write to offset 6 replaces pointer bits 7:0 and a write to offset 7 replaces bits 15:8; neither write changes the other byte.
- R3: A read of offset 6 returns pointer bits 7:0. A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7. Both are returned one cycle after the request, with `rdata_valid` high.
- R4: Every data access drives `mem_addr` as {page, byte offset}, with the page in the bits above bit 10. The page is `rx_head` when pointer bit 15 is 1 and `pkt_num` when it is 0.
- R5: When pointer bit 14 is 1, a data access (offsets 8 to 11) uses pointer bits 10:0 as the byte offset. The pointer then advances bits 10:0 by one modulo 2048 and leaves bits 15:11 unchanged.
- R6: When pointer bit 14 is 0, a data access uses the byte offset (pointer bits 10:0 + `reg_addr[1:0]`) modulo 2048 and leaves the pointer unchanged.
- R7: A data write asserts `mem_en` and `mem_we` in the same cycle, with `reg_wdata` on `mem_wdata`.
- R8: A data read asserts `mem_en` with `mem_we` low. One cycle later `rdata_valid` is high and `rdata` carries `mem_rdata`.
- R9: A write to any offset other than 6 to 11 changes nothing. A read of such an offset returns 0x00 with `rdata_valid` high one cycle later.
- R10: When `reg_rd` and `reg_wr` are both high, only the write takes place, and `rdata_valid` stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe, one byte |
| reg_wr | input | 1 | Register write strobe, one byte |
| reg_addr | input | 4 | Register offset (6/7 pointer, 8..11 data) |
| reg_wdata | input | 8 | Write byte |
| pkt_num | input | PG_W | Page from the packet-number register |
| rx_head | input | PG_W | Page at the receive-queue head |
| rdata_valid | output | 1 | Read data valid, one cycle after a read |
| rdata | output | 8 | Read data byte |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PG_W+11 | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after `mem_en` |

## Verification
Every cycle, the checker confirms several properties. The page on `mem_addr` must follow pointer bit 15. An auto-incrementing access must step only the low 11 pointer bits, and an access without auto-increment must leave the pointer alone. A write must never cause a read return, and a read alone must always produce one. The bench's scenarios show the rest: that the returned byte is the right one from the right page, the 0xF7 mask on the high byte, the offset-plus-lane wrap at the page end, the 2047-to-0 wrap of the increment, and that offsets outside the window leave the pointer untouched.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int PTR_W    = 16;
  localparam int OFF_W    = 11;
  localparam int SEL_BIT  = 15;
  localparam int AUTO_BIT = 14;
  localparam logic [3:0] OFS_PTR_LO = 4'd6;
  localparam logic [3:0] OFS_PTR_HI = 4'd7;
  localparam logic [7:0] HI_MASK    = 8'hF7;

  typedef enum logic [1:0] {RET_NONE, RET_REG, RET_MEM} ret_e;

  // data window spans offsets 8..11
  function automatic logic is_data(input logic [3:0] a);
    return a[3:2] == 2'b10;
  endfunction

  function automatic logic [OFF_W-1:0] access_off(input logic [PTR_W-1:0] p,
                                                  input logic [1:0] lane);
    if (p[AUTO_BIT]) return p[OFF_W-1:0];
    return p[OFF_W-1:0] + OFF_W'(lane);
  endfunction

  function automatic logic [PTR_W-1:0] bump_ptr(input logic [PTR_W-1:0] p);
    logic [OFF_W-1:0] nxt;
    nxt = p[OFF_W-1:0] + OFF_W'(1);
    return {p[PTR_W-1:OFF_W], nxt};
  endfunction

  function automatic logic [7:0] hi_view(input logic [PTR_W-1:0] p);
    return p[15:8] & HI_MASK;
  endfunction
endpackage

// File: rtl/bdp_ptr_reg.sv
module bdp_ptr_reg
  import bdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  input  logic             bump,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (wr_lo) begin
      ptr <= {ptr[15:8], wdata};
    end else if (wr_hi) begin
      ptr <= {wdata, ptr[7:0]};
    end else if (bump) begin
      ptr <= bump_ptr(ptr);
    end
  end
endmodule

// File: rtl/bdp_addr_gen.sv
module bdp_addr_gen
  import bdp_pkg::*;
#(
  parameter int PG_W = 2,
  localparam int MA_W = PG_W + OFF_W
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic [1:0]       lane,
  input  logic [PG_W-1:0]  pkt_num,
  input  logic [PG_W-1:0]  rx_head,
  output logic [MA_W-1:0]  mem_addr
);
  logic [PG_W-1:0] page;
  always_comb begin
    page     = ptr[SEL_BIT] ? rx_head : pkt_num;
    mem_addr = {page, access_off(ptr, lane)};
  end
endmodule

// File: rtl/bdp_rd_return.sv
module bdp_rd_return
  import bdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_mem,
  input  logic       req_reg,
  input  logic [7:0] reg_val,
  input  logic [7:0] mem_rdata,
  output logic       rdata_valid,
  output logic [7:0] rdata
);
  ret_e       kind_q;
  logic [7:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RET_NONE;
      held_q <= '0;
    end else begin
      kind_q <= req_mem ? RET_MEM : (req_reg ? RET_REG : RET_NONE);
      if (req_reg) held_q <= reg_val;
    end
  end

  assign rdata_valid = (kind_q != RET_NONE);
  assign rdata       = (kind_q == RET_MEM) ? mem_rdata : held_q;
endmodule

// File: rtl/buf_data_port.sv
module buf_data_port
  import bdp_pkg::*;
#(
  parameter int PAGES = 4,
  localparam int PG_W = (PAGES > 1) ? $clog2(PAGES) : 1,
  localparam int MA_W = PG_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_rd,
  input  logic            reg_wr,
  input  logic [3:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  input  logic [PG_W-1:0] pkt_num,
  input  logic [PG_W-1:0] rx_head,
  output logic            rdata_valid,
  output logic [7:0]      rdata,
  output logic            mem_en,
  output logic            mem_we,
  output logic [MA_W-1:0] mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata
);
  logic [PTR_W-1:0] ptr;
  logic rd_only, data_hit, data_wr, data_rd, bump, wr_lo, wr_hi, rd_reg;
  logic [7:0] reg_val;

  // write wins when both strobes are high
  assign rd_only  = reg_rd & ~reg_wr;
  assign data_hit = is_data(reg_addr);
  assign data_wr  = reg_wr & data_hit;
  assign data_rd  = rd_only & data_hit;
  assign bump     = (data_wr | data_rd) & ptr[AUTO_BIT];
  assign wr_lo    = reg_wr & (reg_addr == OFS_PTR_LO);
  assign wr_hi    = reg_wr & (reg_addr == OFS_PTR_HI);
  assign rd_reg   = rd_only & ~data_hit;

  always_comb begin
    if (reg_addr == OFS_PTR_LO)      reg_val = ptr[7:0];
    else if (reg_addr == OFS_PTR_HI) reg_val = hi_view(ptr);
    else                             reg_val = 8'h00;
  end

  bdp_ptr_reg u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(reg_wdata), .bump(bump), .ptr(ptr)
  );

  bdp_addr_gen #(.PG_W(PG_W)) u_agen (
    .ptr(ptr), .lane(reg_addr[1:0]), .pkt_num(pkt_num),
    .rx_head(rx_head), .mem_addr(mem_addr)
  );

  bdp_rd_return u_ret (
    .clk(clk), .rst_n(rst_n), .req_mem(data_rd), .req_reg(rd_reg),
    .reg_val(reg_val), .mem_rdata(mem_rdata),
    .rdata_valid(rdata_valid), .rdata(rdata)
  );

  assign mem_en    = data_wr | data_rd;
  assign mem_we    = data_wr;
  assign mem_wdata = reg_wdata;
endmodule

// File: rtl/bdp_chk.sv
module bdp_chk #(
  parameter int PG_W = 2,
  localparam int MA_W = PG_W + 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_rd,
  input logic            reg_wr,
  input logic [PG_W-1:0] pkt_num,
  input logic [PG_W-1:0] rx_head,
  input logic [15:0]     ptr,
  input logic            mem_en,
  input logic            mem_we,
  input logic [MA_W-1:0] mem_addr,
  input logic            rdata_valid
);
  // R4
  page_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[MA_W-1:11] == (ptr[15] ? rx_head : pkt_num)));

  // R5
  autoinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && ptr[14]) |=> ((ptr[10:0] == $past(ptr[10:0]) + 11'd1) &&
                             (ptr[15:11] == $past(ptr[15:11]))));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !ptr[14]) |=> $stable(ptr));

  // R7
  we_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && reg_wr));

  // R8
  rd_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> rdata_valid);

  // R10
  wr_no_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !rdata_valid);
endmodule

bind buf_data_port bdp_chk #(.PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .pkt_num(pkt_num), .rx_head(rx_head), .ptr(ptr), .mem_en(mem_en),
  .mem_we(mem_we), .mem_addr(mem_addr), .rdata_valid(rdata_valid)
);

// File: tb/sim_buf_data_port.sv
module sim_buf_data_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [1:0] pkt_num = 2'd2, rx_head = 2'd1;
  logic rdata_valid, mem_en, mem_we;
  logic [7:0] rdata, mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic [12:0] mem_addr;

  int n_tests = 0, n_fail = 0;
  logic [15:0] mptr = 16'h0000;
  logic [7:0] mem [0:8191];

  always #2 clk = ~clk;

  buf_data_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pkt_num(pkt_num),
    .rx_head(rx_head), .rdata_valid(rdata_valid), .rdata(rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // synchronous memory with one cycle of read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // bench's own view of the byte address a data access reaches
  function automatic int model_addr(input int lane);
    int page, off;
    page = mptr[15] ? int'(rx_head) : int'(pkt_num);
    if (mptr[14]) off = int'(mptr) % 2048;
    else          off = (int'(mptr) % 2048 + lane) % 2048;
    return page * 2048 + off;
  endfunction

  function automatic void model_step();
    int off;
    if (mptr[14]) begin
      off = (int'(mptr) % 2048 + 1) % 2048;
      mptr = (mptr & 16'hF800) | 16'(off);
    end
  endfunction

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d, input string req);
    int ma;
    ma = model_addr(int'(a[1:0]));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 4'd6) mptr[7:0] = d;
    else if (a == 4'd7) mptr[15:8] = d;
    else if (a >= 4'd8 && a <= 4'd11) begin
      chk({req, " mem byte written"}, int'(mem[ma]), int'(d));
      model_step();
    end
  endtask

  task automatic do_rd(input logic [3:0] a, input string req);
    int exp;
    if (a >= 4'd8 && a <= 4'd11) exp = int'(mem[model_addr(int'(a[1:0]))]);
    else if (a == 4'd6) exp = int'(mptr[7:0]);
    else if (a == 4'd7) exp = int'(mptr[15:8] & 8'hF7);
    else exp = 0;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, int'({rdata_valid, rdata}), 256 + exp);
    if (a >= 4'd8 && a <= 4'd11) model_step();
  endtask

  // {is_read, reg offset, write byte}
  localparam logic [12:0] VEC [15] = '{
    {1'b0, 4'd6, 8'h10}, {1'b0, 4'd7, 8'h00}, {1'b1, 4'd8, 8'h00},
    {1'b1, 4'd9, 8'h00}, {1'b1, 4'd11, 8'h00}, {1'b0, 4'd7, 8'h40},
    {1'b1, 4'd8, 8'h00}, {1'b1, 4'd10, 8'h00}, {1'b1, 4'd6, 8'h00},
    {1'b0, 4'd7, 8'hC0}, {1'b0, 4'd8, 8'h5A}, {1'b1, 4'd6, 8'h00},
    {1'b0, 4'd6, 8'h12}, {1'b1, 4'd8, 8'h00}, {1'b1, 4'd7, 8'h00}
  };

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) mem[i] = 8'(i) ^ {i[12:8], 3'b101};
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", int'(rdata_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid low after reset", int'(rdata_valid), 0);
    do_rd(4'd6, "R1 R3 ptr low after reset");
    do_rd(4'd7, "R1 R3 ptr high after reset");

    // table walk: R2 R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      if (VEC[i][12]) do_rd(VEC[i][11:8], "R4 R5 R6 R8 vector read");
      else            do_wr(VEC[i][11:8], VEC[i][7:0], "R2 R7 vector write");
    end

    // R3 high byte mask, R2 byte independence
    do_wr(4'd6, 8'h3C, "R2");
    do_wr(4'd7, 8'hFF, "R2");
    do_rd(4'd7, "R3 high byte masked with F7");
    do_rd(4'd6, "R2 low byte kept after high write");

    // R5 increment wraps 2047 -> 0, upper bits kept
    do_wr(4'd6, 8'hFF, "R5");
    do_wr(4'd7, 8'h47, "R5");
    do_rd(4'd9, "R5 read at offset 2047");
    do_rd(4'd6, "R5 low byte wrapped");
    do_rd(4'd7, "R5 upper bits unchanged");

    // R6 offset plus lane wraps within the page, pointer unchanged
    do_wr(4'd6, 8'hFE, "R6");
    do_wr(4'd7, 8'h07, "R6");
    do_rd(4'd11, "R6 lane 3 wraps to offset 1");
    do_rd(4'd6, "R6 pointer low unchanged");

    // R4 page selection follows the inputs
    pkt_num = 2'd3; rx_head = 2'd0;
    do_rd(4'd10, "R4 packet-number page");
    do_wr(4'd7, 8'h87, "R4");
    do_rd(4'd10, "R4 receive-head page");

    // R9 other offsets
    do_wr(4'd3, 8'hAA, "R9");
    do_wr(4'd13, 8'h55, "R9");
    do_rd(4'd6, "R9 write elsewhere left ptr low");
    do_rd(4'd7, "R9 write elsewhere left ptr high");
    do_rd(4'd3, "R9 other offset reads zero");

    // R10 simultaneous strobes: write only
    begin
      int ma;
      ma = model_addr(1);
      @(negedge clk);
      reg_rd = 1'b1; reg_wr = 1'b1; reg_addr = 4'd9; reg_wdata = 8'hC3;
      @(negedge clk);
      reg_rd = 1'b0; reg_wr = 1'b0;
      chk("R10 no read return", int'(rdata_valid), 0);
      chk("R10 write performed", int'(mem[ma]), 8'hC3);
      model_step();
    end
    do_rd(4'd9, "R10 R8 read back");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule